// File: doc/BRIEF.md
# I2C Target Interface with Masked Four-Slot Address Recognition

This block is the target (responding) side of an I2C bus. It watches the SDA and SCL lines, which are already synchronized to the system clock. It finds the start, repeated-start and stop conditions, and shifts in the first byte of each transfer. It compares that byte with four programmable 7-bit addresses, each of which has its own compare mask. It also recognises the general-call address when any slot enables it. When an address is accepted, the block pulls SDA low for the acknowledge pulse and then either receives data bytes or transmits them, as the direction bit selects.

Every accepted address, received byte and transmit acknowledge produces a one-cycle event pulse together with an event kind. For address and receive events, the full received byte is held on the byte output. The host works out which slot hit by reading the address byte that was captured. The block drives SDA only through an output enable: when the enable is high, the line is pulled low.

Top module: `i2cs_multi_addr`

## Requirements
- R1: A fall of SDA while SCL is high begins address reception. A rise of SDA while SCL is high returns the block to idle from any state, clears `addressed_o` and releases SDA.
- R2: A start condition that arrives before any stop restarts address reception at once and clears `addressed_o`. A later address that does not match leaves the block unaddressed.
- R3: The address byte is shifted in MSB first, one bit on each SCL rise. Bits 7..1 are the address and bit 0 is the direction bit (0 = master writes, 1 = master reads). Slot k hits when the received address equals bits 7..1 of its address field at every bit position where its 7-bit mask holds a 1.
- R4: Address bits whose mask bit is 0 are don't-care. A slot whose mask is 0x70 and whose address is 0x20 accepts every address from 0x20 to 0x2F.
- R5: A received address of 0x00 is accepted as a general call when bit 0 of at least one slot's address field is 1. If no slot sets that bit, 0x00 is not acknowledged.
- R6: When an address hits and `ack_en_i` is 1, the block pulls SDA low during the ninth SCL pulse. When the address misses, or `ack_en_i` is 0, SDA stays released and the rest of the transfer raises no event.
- R7: An accepted address raises `evt_o` for one cycle. The kind is 0 for a write or 1 for a read, and `rx_byte_o` holds the whole address byte, including the direction bit.
- R8: In a write transfer, each data byte raises an event of kind 2 with the byte on `rx_byte_o`. The byte is acknowledged only when `ack_en_i` is 1.
- R9: In a read transfer, the block sends `tx_byte_i` MSB first. The byte is sampled at the SCL fall that ends the preceding acknowledge pulse. SDA is released during every ninth pulse.
- R10: A master ACK on the ninth pulse of a transmitted byte raises an event of kind 3, and the next byte follows. A master NACK raises an event of kind 4, clears `addressed_o` and keeps SDA released until the next start.
- R11: `addressed_o` is high from the address acknowledge until a stop, a repeated start or a master NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ack_en_i | input | 1 | Allow acknowledge of addresses and received data |
| slot_addr_i | input | 32 | Four address fields: bits 7..1 address, bit 0 general-call enable; slot k at bits 8k+7..8k |
| slot_mask_i | input | 28 | Four 7-bit compare masks; slot k at bits 7k+6..7k |
| tx_byte_i | input | 8 | Byte to transmit in read transfers |
| rx_byte_o | output | 8 | Last captured address or data byte |
| evt_o | output | 1 | One-cycle event pulse |
| evt_kind_o | output | 3 | Event kind: 0 addr write, 1 addr read, 2 data received, 3 tx acked, 4 tx nacked |
| addressed_o | output | 1 | Block currently selected |

## Verification
The bench targets the masked slot, where an address differing from the slot value only in masked-out bits must still be acknowledged. A design that compared all seven bits would refuse it. It checks that general call is accepted only while some slot enables it, and that a miss stays silent through the following data byte; a design that latched a stale match would acknowledge that byte or raise events for it. It covers a repeated start into a read, a repeated start to a foreign address, and a stop in the middle of a byte. A block that waited for idle would lose the second address, and one that ignored the early stop would stay addressed. It also checks that after a master NACK the line reads all ones, because a transmitter that kept shifting would corrupt the bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } i2cs_state_e;

  typedef enum logic [2:0] {
    EV_ADDR_WR   = 3'd0,
    EV_ADDR_RD   = 3'd1,
    EV_DATA_RX   = 3'd2,
    EV_TX_ACKED  = 3'd3,
    EV_TX_NACKED = 3'd4
  } i2cs_evt_e;

endpackage

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q;
  logic sda_q;

  // Previous-sample registers; idle bus is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0]         rx_addr_i,
  input  logic [SLOTS*(ADDR_W+1)-1:0] slot_addr_i,
  input  logic [SLOTS*ADDR_W-1:0]   slot_mask_i,
  output logic                      hit_o
);

  localparam int FIELD_W = ADDR_W + 1;

  logic [SLOTS-1:0] slot_hit;
  logic [SLOTS-1:0] gc_en;
  logic             gc_hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [ADDR_W-1:0] slot_a;
    logic [ADDR_W-1:0] slot_m;
    assign slot_a      = slot_addr_i[g*FIELD_W+1 +: ADDR_W];
    assign slot_m      = slot_mask_i[g*ADDR_W +: ADDR_W];
    assign gc_en[g]    = slot_addr_i[g*FIELD_W];
    assign slot_hit[g] = ~|((rx_addr_i ^ slot_a) & slot_m);
  end

  assign gc_hit = (rx_addr_i == '0) & (|gc_en);
  assign hit_o  = (|slot_hit) | gc_hit;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              ack_en_i,
  input  logic              addr_hit_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic              sda_oe_o,
  output logic              addressed_o,
  output logic              evt_o,
  output logic [2:0]        evt_kind_o,
  output logic [DATA_W-1:0] rx_byte_o
);

  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W);

  i2cs_state_e       state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rxb_q, rxb_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              oe_q, oe_d;
  logic              addr_q, addr_d;
  logic              evt_q, evt_d;
  i2cs_evt_e         kind_q, kind_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    tx_d    = tx_q;
    rxb_d   = rxb_q;
    cnt_d   = cnt_q;
    oe_d    = oe_q;
    addr_d  = addr_q;
    evt_d   = 1'b0;
    kind_d  = kind_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      addr_d  = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      addr_d  = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (rise_i) begin
            shreg_d = {shreg_q[DATA_W-2:0], sda_i};
            cnt_d   = cnt_q + CW'(1);
          end else if (fall_i && cnt_q == LAST_BIT) begin
            if (addr_hit_i && ack_en_i) begin
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
              addr_d  = 1'b1;
              rxb_d   = shreg_q;
              evt_d   = 1'b1;
              kind_d  = shreg_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (fall_i) begin
            cnt_d = '0;
            if (shreg_q[0]) begin
              state_d = ST_TX;
              tx_d    = tx_byte_i;
              oe_d    = ~tx_byte_i[DATA_W-1];
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
            end
          end
        end
        ST_RX: begin
          if (rise_i) begin
            shreg_d = {shreg_q[DATA_W-2:0], sda_i};
            cnt_d   = cnt_q + CW'(1);
          end else if (fall_i && cnt_q == LAST_BIT) begin
            state_d = ST_RX_ACK;
            rxb_d   = shreg_q;
            evt_d   = 1'b1;
            kind_d  = EV_DATA_RX;
            oe_d    = ack_en_i;
          end
        end
        ST_RX_ACK: begin
          if (fall_i) begin
            state_d = ST_RX;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_TX: begin
          if (rise_i) begin
            cnt_d = cnt_q + CW'(1);
          end else if (fall_i) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_TX_ACK;
              oe_d    = 1'b0;
            end else begin
              tx_d = {tx_q[DATA_W-2:0], 1'b0};
              oe_d = ~tx_q[DATA_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (rise_i) begin
            evt_d = 1'b1;
            if (sda_i) begin
              kind_d  = EV_TX_NACKED;
              state_d = ST_IGNORE;
              addr_d  = 1'b0;
            end else begin
              kind_d = EV_TX_ACKED;
            end
          end else if (fall_i) begin
            state_d = ST_TX;
            cnt_d   = '0;
            tx_d    = tx_byte_i;
            oe_d    = ~tx_byte_i[DATA_W-1];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      tx_q    <= '0;
      rxb_q   <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      addr_q  <= 1'b0;
      evt_q   <= 1'b0;
      kind_q  <= EV_ADDR_WR;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      tx_q    <= tx_d;
      rxb_q   <= rxb_d;
      cnt_q   <= cnt_d;
      oe_q    <= oe_d;
      addr_q  <= addr_d;
      evt_q   <= evt_d;
      kind_q  <= kind_d;
    end
  end

  assign shreg_o     = shreg_q;
  assign sda_oe_o    = oe_q;
  assign addressed_o = addr_q;
  assign evt_o       = evt_q;
  assign evt_kind_o  = kind_q;
  assign rx_byte_o   = rxb_q;

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_q == ST_IDLE && !addr_q && !oe_q)); // R1

  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (state_q == ST_ADDR && cnt_q == '0 && !addr_q)); // R2

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_i); // R6

  AST_TX_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK) |-> !oe_q); // R9

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q); // R7

endmodule

// File: rtl/i2cs_multi_addr.sv
module i2cs_multi_addr #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic                     ack_en_i,
  input  logic [SLOTS*DATA_W-1:0]  slot_addr_i,
  input  logic [SLOTS*(DATA_W-1)-1:0] slot_mask_i,
  input  logic [DATA_W-1:0]        tx_byte_i,
  output logic [DATA_W-1:0]        rx_byte_o,
  output logic                     evt_o,
  output logic [2:0]               evt_kind_o,
  output logic                     addressed_o
);

  localparam int ADDR_W = DATA_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start, stop, rise, fall;
  logic              addr_hit;
  logic [DATA_W-1:0] shreg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2cs_cond_det u_cond (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (rise),
    .scl_fall_o (fall)
  );

  i2cs_addr_match #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_match (
    .rx_addr_i   (shreg[DATA_W-1:1]),
    .slot_addr_i (slot_addr_i),
    .slot_mask_i (slot_mask_i),
    .hit_o       (addr_hit)
  );

  i2cs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_i     (start),
    .stop_i      (stop),
    .rise_i      (rise),
    .fall_i      (fall),
    .ack_en_i    (ack_en_i),
    .addr_hit_i  (addr_hit),
    .tx_byte_i   (tx_byte_i),
    .shreg_o     (shreg),
    .sda_oe_o    (sda_oe_o),
    .addressed_o (addressed_o),
    .evt_o       (evt_o),
    .evt_kind_o  (evt_kind_o),
    .rx_byte_o   (rx_byte_o)
  );

endmodule

// File: tb/i2cs_multi_addr_tb.sv
module i2cs_multi_addr_tb_top;

  localparam int Q = 4;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_oe;
  logic        sda_bus;
  logic        ack_en;
  logic [31:0] slot_addr;
  logic [27:0] slot_mask;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte;
  logic        evt;
  logic [2:0]  evt_kind;
  logic        addressed;
  logic        done = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  logic [10:0] exp_q[$];

  assign sda_bus = sda_m & ~sda_oe;

  i2cs_multi_addr dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .ack_en_i    (ack_en),
    .slot_addr_i (slot_addr),
    .slot_mask_i (slot_mask),
    .tx_byte_i   (tx_byte),
    .rx_byte_o   (rx_byte),
    .evt_o       (evt),
    .evt_kind_o  (evt_kind),
    .addressed_o (addressed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    qwait();
    scl_m = 1'b1; qwait();
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus;  qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(r);
    chk(r == !exp_ack, req, int'(r), int'(!exp_ack));
  endtask

  task automatic read_byte(input logic [7:0] exp, input bit mack,
                           input logic [7:0] next_tx, input string req);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    chk(v == exp, req, int'(v), int'(exp));
    tx_byte = next_tx;
    send_bit(!mack);
  endtask

  task automatic expect_evt(input logic [2:0] kind, input logic [7:0] b);
    exp_q.push_back({kind, b});
  endtask

  // Monitor: pops the scoreboard as events appear.
  always @(negedge clk) begin
    if (rst_n && evt) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6/R7 unexpected event", int'(evt_kind), 7);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(evt_kind == e[10:8], "R7/R8/R10 event kind", int'(evt_kind), int'(e[10:8]));
        if (e[10:8] <= 3'd2)
          chk(rx_byte == e[7:0], "R7/R8 event byte", int'(rx_byte), int'(e[7:0]));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    scl_m     = 1'b1;
    sda_m     = 1'b1;
    ack_en    = 1'b1;
    slot_addr = {8'hFE, 8'h67, 8'h40, 8'hA0};
    slot_mask = {7'h7F, 7'h7F, 7'h70, 7'h7F};
    tx_byte   = 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    chk(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    chk(addressed == 1'b0, "R11 reset addressed", int'(addressed), 0);
    chk(evt == 1'b0, "R7 reset evt", int'(evt), 0);

    // R3: exact-match slot, write two bytes
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R3 ack slot0 write");
    chk(addressed == 1'b1, "R11 addressed after ack", int'(addressed), 1);
    expect_evt(3'd2, 8'h3C);
    write_byte(8'h3C, 1'b1, "R8 data ack 3C");
    expect_evt(3'd2, 8'hC3);
    write_byte(8'hC3, 1'b1, "R8 data ack C3");
    bus_stop();
    qwait();
    chk(addressed == 1'b0, "R1 stop clears addressed", int'(addressed), 1'b0);

    // R4: masked slot accepts 0x2B
    bus_start();
    expect_evt(3'd0, 8'h56);
    write_byte(8'h56, 1'b1, "R4 masked slot ack");
    expect_evt(3'd2, 8'h81);
    write_byte(8'h81, 1'b1, "R8 data ack 81");
    bus_stop();

    // R6: miss, data byte silent
    bus_start();
    write_byte(8'h80, 1'b0, "R6 miss nack");
    chk(addressed == 1'b0, "R6 miss not addressed", int'(addressed), 0);
    write_byte(8'h00, 1'b0, "R6 data after miss nack");
    bus_stop();

    // R5: general call enabled, then disabled
    bus_start();
    expect_evt(3'd0, 8'h00);
    write_byte(8'h00, 1'b1, "R5 general call ack");
    expect_evt(3'd2, 8'h11);
    write_byte(8'h11, 1'b1, "R8 gc data ack");
    bus_stop();
    slot_addr[16] = 1'b0;
    bus_start();
    write_byte(8'h00, 1'b0, "R5 general call disabled nack");
    bus_stop();
    slot_addr[16] = 1'b1;

    // R9/R10: read two bytes, ACK then NACK, line stays released
    tx_byte = 8'hA5;
    bus_start();
    expect_evt(3'd1, 8'hFF);
    write_byte(8'hFF, 1'b1, "R7 read address ack");
    expect_evt(3'd3, 8'h00);
    read_byte(8'hA5, 1'b1, 8'h5A, "R9 first tx byte");
    expect_evt(3'd4, 8'h00);
    read_byte(8'h5A, 1'b0, 8'h00, "R9 second tx byte");
    chk(addressed == 1'b0, "R10 nack clears addressed", int'(addressed), 0);
    read_byte(8'hFF, 1'b0, 8'h00, "R10 released after nack");
    bus_stop();

    // R2: repeated start into read
    tx_byte = 8'h3E;
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R2 first address ack");
    expect_evt(3'd2, 8'h01);
    write_byte(8'h01, 1'b1, "R2 register byte ack");
    bus_start();
    expect_evt(3'd1, 8'hFF);
    write_byte(8'hFF, 1'b1, "R2 restart read ack");
    expect_evt(3'd4, 8'h00);
    read_byte(8'h3E, 1'b0, 8'h00, "R2 restart read data");
    bus_stop();

    // R2: repeated start to a foreign address
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R2 address ack");
    bus_start();
    write_byte(8'h80, 1'b0, "R2 restart miss nack");
    chk(addressed == 1'b0, "R2 restart miss unaddressed", int'(addressed), 0);
    bus_stop();

    // R6/R8: acknowledge disabled
    ack_en = 1'b0;
    bus_start();
    write_byte(8'hA0, 1'b0, "R6 ack disabled address nack");
    chk(addressed == 1'b0, "R6 ack disabled unaddressed", int'(addressed), 0);
    bus_stop();
    ack_en = 1'b1;
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R6 address ack");
    ack_en = 1'b0;
    expect_evt(3'd2, 8'h77);
    write_byte(8'h77, 1'b0, "R8 data nack when disabled");
    ack_en = 1'b1;
    bus_stop();

    // R1: stop in the middle of a byte
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R1 address ack");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    qwait();
    chk(addressed == 1'b0, "R1 mid-byte stop unaddressed", int'(addressed), 0);
    chk(sda_oe == 1'b0, "R1 mid-byte stop released", int'(sda_oe), 0);
    bus_start();
    expect_evt(3'd0, 8'hA0);
    write_byte(8'hA0, 1'b1, "R1 next transfer ack");
    bus_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule